// File: doc/BRIEF.md
# Channel Trigger Selector with One-Shot Software Force

This block decides when a single transfer channel moves its next data element. It watches a wide vector of request lines coming from peripherals, picks one of them with a selector, and turns each rising edge on the chosen line into one transfer request for the channel's sequencer. Software can also arm a one-shot force flag. The channel then performs exactly one element transfer without waiting for a peripheral. Hardware alone clears the flag once that transfer is acknowledged. After that the channel goes back to following the selected request line.

A request, once raised, stays asserted until the sequencer reports completion on the done input. Request edges that arrive in the meantime are dropped, not queued. While the channel enable is low, no new request is raised. A force flag armed during that time waits and fires as soon as the channel is enabled. A separate output tells the sequencer whether the current request came from the force flag or from the hardware line.

Top module: `dma_trig_select`

## Requirements
- R1: After a synchronous reset, `xfer_req`, `xfer_forced` and `force_flag` are all 0.
- R2: The selector value k (0 to NUM_SRC-1, including the top index) picks line k of `req_lines`. When that line rises while the channel is enabled and no request is pending, `xfer_req` is 1 after the first clock edge that sees the line high, with `xfer_forced` 0. Rising edges on any other line raise nothing.
- R3: A selected line that stays high produces only one request. A further request needs the line to fall and rise again.
- R4: A raised request stays asserted until a clock edge with `xfer_done` 1 and is 0 after that edge. Edges on the selected line while the request is pending are dropped: no request follows the acknowledgement.
- R5: A clock edge with `force_wr` 1 and `force_wdata` 1, while no request is pending, sets `force_flag`. If the channel is enabled, `xfer_req` rises one edge later with `xfer_forced` 1.
- R6: `force_flag` is cleared only by the edge that acknowledges the forced request (`xfer_done` 1). A software write with `force_wdata` 0 leaves it unchanged.
- R7: A write that sets the force flag while a request is pending has no effect: `force_flag` stays 0 and no forced request follows.
- R8: A forced request moves exactly one element. After its acknowledgement no further request is raised without a new rising edge on the selected line, and such an edge again raises a hardware request (`xfer_forced` 0).
- R9: While `chan_en` is 0, no new request is raised and line edges are dropped. A force flag armed in that time stays set, and the forced request is raised at the first edge with `chan_en` 1.
- R10: When the force flag is set and a selected-line edge arrives in the same idle cycle, the forced request wins and the coinciding line edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| req_lines | input | NUM_SRC | Peripheral request lines |
| src_sel | input | SEL_W | Index of the request line that triggers the channel |
| force_wr | input | 1 | Software write strobe for the force flag |
| force_wdata | input | 1 | Value written to the force flag (only 1 has an effect) |
| xfer_done | input | 1 | Sequencer reports that the pending element transfer completed |
| xfer_req | output | 1 | Registered transfer request, held until acknowledged |
| xfer_forced | output | 1 | Registered: the pending request came from the force flag |
| force_flag | output | 1 | Registered software-visible force flag |

## Verification
A selected-line edge shows on `xfer_req` after one clock edge. A force write shows on `force_flag` after one edge and on `xfer_req` after two. An acknowledgement drops `xfer_req` and `force_flag` at the edge that samples `xfer_done`. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next edge or edges, so each check lands exactly on the cycle its result is due. For the dropped-edge and ignored-write cases, it keeps watching the outputs for several further edges to confirm that nothing late appears.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Origin of the currently pending transfer request.
  typedef enum logic {
    SRC_HW    = 1'b0,
    SRC_FORCE = 1'b1
  } trig_src_e;
endpackage

// File: rtl/trig_edge_bank.sv
module trig_edge_bank #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  output logic [N-1:0] rises
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lines[i];
    end
    assign rises[i] = lines[i] & ~prev_q[i];
  end
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int N     = 128,
  parameter int SEL_W = 7
) (
  input  logic [N-1:0]     rises,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) hit = rises[i];
    end
  end
endmodule

// File: rtl/trig_force_ctl.sv
module trig_force_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_data,
  input  logic busy,
  input  logic hw_clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                                flag <= 1'b0;
    else if (hw_clear)                      flag <= 1'b0;
    else if (wr_en && wr_data && !busy)     flag <= 1'b1;
  end
endmodule

// File: rtl/trig_issue.sv
module trig_issue
  import trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      hw_hit,
  input  logic      force_set,
  input  logic      done,
  output logic      req,
  output trig_src_e src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      src <= SRC_HW;
    end else if (req) begin
      if (done) begin
        req <= 1'b0;
        src <= SRC_HW;
      end
    end else if (en) begin
      if (force_set) begin
        req <= 1'b1;
        src <= SRC_FORCE;
      end else if (hw_hit) begin
        req <= 1'b1;
        src <= SRC_HW;
      end
    end
  end
endmodule

// File: rtl/dma_trig_select.sv
module dma_trig_select
  import trig_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_en,
  input  logic [NUM_SRC-1:0] req_lines,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               force_wr,
  input  logic               force_wdata,
  input  logic               xfer_done,
  output logic               xfer_req,
  output logic               xfer_forced,
  output logic               force_flag
);
  logic [NUM_SRC-1:0] line_rise;
  logic               sel_hit;
  logic               forced_ack;
  trig_src_e          pend_src;

  trig_edge_bank #(.N(NUM_SRC)) u_edges (
    .clk   (clk),
    .rst   (rst),
    .lines (req_lines),
    .rises (line_rise)
  );

  trig_src_mux #(.N(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .rises (line_rise),
    .sel   (src_sel),
    .hit   (sel_hit)
  );

  assign forced_ack = xfer_req && (pend_src == SRC_FORCE) && xfer_done;

  trig_force_ctl u_force (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (force_wr),
    .wr_data  (force_wdata),
    .busy     (xfer_req),
    .hw_clear (forced_ack),
    .flag     (force_flag)
  );

  trig_issue u_issue (
    .clk       (clk),
    .rst       (rst),
    .en        (chan_en),
    .hw_hit    (sel_hit),
    .force_set (force_flag),
    .done      (xfer_done),
    .req       (xfer_req),
    .src       (pend_src)
  );

  assign xfer_forced = (pend_src == SRC_FORCE);
endmodule

// File: rtl/trig_checker.sv
module trig_checker (
  input logic clk,
  input logic rst,
  input logic chan_en,
  input logic force_wr,
  input logic force_wdata,
  input logic xfer_done,
  input logic xfer_req,
  input logic xfer_forced,
  input logic force_flag
);
  // R4: a pending request is held until acknowledged
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> xfer_req);

  // R4: acknowledgement drops the request
  assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_done) |=> !xfer_req);

  // R9: disabled idle channel raises nothing
  assert_no_req_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (!chan_en && !xfer_req) |=> !xfer_req);

  // R7: force flag frozen while a request is pending and not acknowledged
  assert_flag_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> $stable(force_flag));

  // R6: a zero write never clears the flag
  assert_zero_write_R6: assert property (@(posedge clk) disable iff (rst)
    (force_flag && force_wr && !force_wdata && !xfer_done) |=> force_flag);

  // R5: a forced request always has its flag set
  assert_forced_has_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_forced) |-> force_flag);

  // R8: after a forced acknowledgement no request without a new trigger
  assert_one_element_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_forced && xfer_done) |=> !force_flag);
endmodule

bind dma_trig_select trig_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .chan_en     (chan_en),
  .force_wr    (force_wr),
  .force_wdata (force_wdata),
  .xfer_done   (xfer_done),
  .xfer_req    (xfer_req),
  .xfer_forced (xfer_forced),
  .force_flag  (force_flag)
);

// File: tb/sim_dma_trig_select.sv
`timescale 1ns/1ps
module sim_dma_trig_select;
  localparam int NSRC = 128;
  localparam int SW   = $clog2(NSRC);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            chan_en = 1'b0;
  logic [NSRC-1:0] req_lines = '0;
  logic [SW-1:0]   src_sel = '0;
  logic            force_wr = 1'b0;
  logic            force_wdata = 1'b0;
  logic            xfer_done = 1'b0;
  logic            xfer_req, xfer_forced, force_flag;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_trig_select #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .req_lines(req_lines),
    .src_sel(src_sel), .force_wr(force_wr), .force_wdata(force_wdata),
    .xfer_done(xfer_done), .xfer_req(xfer_req), .xfer_forced(xfer_forced),
    .force_flag(force_flag)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic ack();
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "xfer_req", xfer_req, 1'b0);
    chk("R1", "xfer_forced", xfer_forced, 1'b0);
    chk("R1", "force_flag", force_flag, 1'b0);
  endtask

  task automatic t_select();
    chan_en = 1'b1; src_sel = 7'd5;
    req_lines[6] = 1'b1; tick();
    chk("R2", "other line ignored", xfer_req, 1'b0);
    req_lines[6] = 1'b0;
    req_lines[5] = 1'b1; tick();
    chk("R2", "selected edge req", xfer_req, 1'b1);
    chk("R2", "hw not forced", xfer_forced, 1'b0);
    tick(2);
    chk("R4", "held until done", xfer_req, 1'b1);
    ack();
    chk("R4", "dropped on done", xfer_req, 1'b0);
    tick(3);
    chk("R3", "held line one req", xfer_req, 1'b0);
    req_lines[5] = 1'b0; tick();
    req_lines[5] = 1'b1; tick();
    chk("R3", "re-edge req", xfer_req, 1'b1);
    ack(); req_lines[5] = 1'b0;
    src_sel = 7'd127; tick();
    req_lines[127] = 1'b1; tick();
    chk("R2", "top index", xfer_req, 1'b1);
    ack(); req_lines[127] = 1'b0; tick();
  endtask

  task automatic t_drop_pending();
    src_sel = 7'd9;
    req_lines[9] = 1'b1; tick();
    chk("R4", "req raised", xfer_req, 1'b1);
    req_lines[9] = 1'b0; tick();
    req_lines[9] = 1'b1; tick();
    ack();
    tick(3);
    chk("R4", "pending edge dropped", xfer_req, 1'b0);
    req_lines[9] = 1'b0; tick();
  endtask

  task automatic t_force();
    force_wr = 1'b1; force_wdata = 1'b1; tick(); force_wr = 1'b0;
    chk("R5", "flag set", force_flag, 1'b1);
    chk("R5", "req not yet", xfer_req, 1'b0);
    tick();
    chk("R5", "forced req", xfer_req, 1'b1);
    chk("R5", "forced marker", xfer_forced, 1'b1);
    force_wr = 1'b1; force_wdata = 1'b0; tick(); force_wr = 1'b0;
    chk("R6", "zero write ignored", force_flag, 1'b1);
    ack();
    chk("R6", "hw cleared flag", force_flag, 1'b0);
    chk("R8", "req dropped", xfer_req, 1'b0);
    tick(3);
    chk("R8", "single element", xfer_req, 1'b0);
    req_lines[9] = 1'b1; tick();
    chk("R8", "back to hw req", xfer_req, 1'b1);
    chk("R8", "hw marker", xfer_forced, 1'b0);
    ack(); req_lines[9] = 1'b0; tick();
  endtask

  task automatic t_force_busy();
    req_lines[9] = 1'b1; tick();
    force_wr = 1'b1; force_wdata = 1'b1; tick(); force_wr = 1'b0;
    chk("R7", "set while busy ignored", force_flag, 1'b0);
    ack();
    tick(3);
    chk("R7", "no forced req later", xfer_req, 1'b0);
    chk("R7", "flag still clear", force_flag, 1'b0);
    req_lines[9] = 1'b0; tick();
  endtask

  task automatic t_disabled();
    chan_en = 1'b0;
    force_wr = 1'b1; force_wdata = 1'b1; tick(); force_wr = 1'b0;
    chk("R9", "flag armed disabled", force_flag, 1'b1);
    req_lines[9] = 1'b1; tick(3);
    chk("R9", "no req disabled", xfer_req, 1'b0);
    chk("R9", "flag pending", force_flag, 1'b1);
    chan_en = 1'b1; tick();
    chk("R9", "forced on enable", xfer_req, 1'b1);
    chk("R9", "forced marker", xfer_forced, 1'b1);
    ack(); tick(2);
    chk("R9", "disabled edge dropped", xfer_req, 1'b0);
    req_lines[9] = 1'b0; tick();
  endtask

  task automatic t_priority();
    force_wr = 1'b1; force_wdata = 1'b1; tick(); force_wr = 1'b0;
    req_lines[9] = 1'b1; tick();
    chk("R10", "force wins", xfer_forced, 1'b1);
    chk("R10", "req up", xfer_req, 1'b1);
    ack(); tick(3);
    chk("R10", "coinciding edge dropped", xfer_req, 1'b0);
    req_lines[9] = 1'b0; tick();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_select();
    t_drop_pending();
    t_force();
    t_force_busy();
    t_disabled();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule